// File: doc/BRIEF.md
# Timer Channel Output-Compare Unit

One timer channel that watches a chosen time base and drives an output pin whenever that time base equals a programmed match value. On each match the pin is either loaded with a programmed polarity bit or toggled. Software can also fire a one-cycle force strobe. The strobe moves the pin exactly as a match would but leaves the flag alone. The time base is either one of several external counter buses or a free-running counter local to the channel.

In the second mode the pin output is frozen and the channel watches an input pin instead. A synchronised edge of the chosen polarity raises the flag. Once raised, the flag becomes a request on either the interrupt line or the DMA line, or on neither, as software selects. The channel also carries a clock-enable mux for a later input filter, which selects either a prescaler tick or every cycle.

Top module: `tmr_oc_chan`

## Requirements
- R1: After reset `pin_o`, `flag_o`, `irq_o` and `dma_o` are 0, and the control word reads back as 0 at address 0.
- R2: In output-compare mode (mode field bits [1:0] = 2'b10) with edge select (bit 2) = 0, a match loads the polarity bit (bit 3) into `pin_o` at the clock edge where the time base equals the match register (address 1).
- R3: In output-compare mode with edge select = 1, each match inverts `pin_o`.
- R4: Bus select (bits [8:7]) picks `cnt_bus_i[k]` for code k < N_BUS and the channel's free-running local counter for code 3. A value on an unselected bus never causes a match.
- R5: Writing the control word with force bit 4 set in output-compare mode updates `pin_o` one edge after the write edge, as a match would, but does not set the flag. Bit 4 always reads back as 0.
- R6: A force strobe and a real match at the same edge produce a single output action, so a toggle inverts the pin only once.
- R7: Outside output-compare mode, neither a force strobe nor a time-base match changes `pin_o` or sets the flag.
- R8: A match sets `flag_o` at the same edge that updates `pin_o`. Writing 1 to bit 0 of the status register (address 2) clears the flag at the capturing edge. A set request wins over a clear at the same edge.
- R9: With flag enable (bit 5) = 1, a set flag drives `dma_o` when the DMA select bit (bit 6) is 1 and `irq_o` when it is 0. With flag enable = 0 both outputs stay low while the flag itself stays set.
- R10: In pin-input mode (mode = 2'b01) with edge select = 0, the flag sets on a rising `pin_i` edge when polarity = 1 and on a falling edge when polarity = 0. The flag becomes visible at the third clock edge after the pin change. With edge select = 1, no edge sets the flag.
- R11: `filt_clk_en_o` equals `presc_tick_i` when the filter-clock bit (bit 9) is 0, and is 1 when that bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Write address: 0 control, 1 match, 2 status |
| wr_data_i | input | DATA_W | Write data |
| rd_addr_i | input | 2 | Read address |
| rd_data_o | output | DATA_W | Read data (combinational) |
| cnt_bus_i | input | N_BUS*CNT_W | External counter buses |
| presc_tick_i | input | 1 | Prescaled clock enable |
| filt_clk_en_o | output | 1 | Selected filter clock enable |
| pin_i | input | 1 | Asynchronous input pin |
| pin_o | output | 1 | Output flip-flop |
| flag_o | output | 1 | Channel flag |
| irq_o | output | 1 | Interrupt request |
| dma_o | output | 1 | DMA request |

## Verification
A table of match pulses steps through every external bus and both match actions. Each entry first pulses the match value on every bus except the selected one, which shows that the bus selection works. It then pulses the match value on the selected bus, and the tracked pin value separates a load from a toggle. Directed cases then try a force strobe on its own and a force that coincides with a match, where one toggle is told apart from two. A force in input mode follows. Input edges of each polarity are applied with edge select clear and set, and the bench checks the flag both before and at its three-edge latency. The routing cases flip flag enable and DMA select while the flag is held set.

// File: rtl/tmr_oc_pkg.sv
package tmr_oc_pkg;
  typedef enum logic [1:0] {
    MODE_OFF    = 2'b00,
    MODE_PIN_IN = 2'b01,
    MODE_OC     = 2'b10,
    MODE_RSVD   = 2'b11
  } chan_mode_e;

  typedef struct packed {
    logic       filt_clk_sel;
    logic [1:0] bus_sel;
    logic       dma_sel;
    logic       flag_en;
    logic       edge_pol;
    logic       edge_sel;
    chan_mode_e mode;
  } chan_ctrl_t;

  localparam logic [1:0] ADDR_CTRL  = 2'd0;
  localparam logic [1:0] ADDR_MATCH = 2'd1;
  localparam logic [1:0] ADDR_STAT  = 2'd2;

  localparam int CTL_ESEL = 2;
  localparam int CTL_EPOL = 3;
  localparam int CTL_FORCE = 4;
  localparam int CTL_FEN  = 5;
  localparam int CTL_DMA  = 6;
  localparam int CTL_BSEL = 7;
  localparam int CTL_FCK  = 9;
  localparam int SEL_W    = 2;
endpackage

// File: rtl/tmr_oc_regs.sv
module tmr_oc_regs import tmr_oc_pkg::*; #(
  parameter int DATA_W = 16,
  parameter int CNT_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [1:0]        rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic              flag_i,
  output chan_ctrl_t        ctrl_o,
  output logic [CNT_W-1:0]  match_o,
  output logic              force_o,
  output logic              flag_clr_o
);
  chan_ctrl_t        ctrl_q;
  logic [CNT_W-1:0]  match_q;
  logic              force_q;
  logic              wr_ctrl;
  logic [DATA_W-1:0] ctrl_word;

  assign wr_ctrl = wr_en_i && (wr_addr_i == ADDR_CTRL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q  <= '0;
      match_q <= '0;
      force_q <= 1'b0;
    end else begin
      force_q <= wr_ctrl && wr_data_i[CTL_FORCE];
      if (wr_ctrl) begin
        ctrl_q.mode         <= chan_mode_e'(wr_data_i[1:0]);
        ctrl_q.edge_sel     <= wr_data_i[CTL_ESEL];
        ctrl_q.edge_pol     <= wr_data_i[CTL_EPOL];
        ctrl_q.flag_en      <= wr_data_i[CTL_FEN];
        ctrl_q.dma_sel      <= wr_data_i[CTL_DMA];
        ctrl_q.bus_sel      <= wr_data_i[CTL_BSEL +: SEL_W];
        ctrl_q.filt_clk_sel <= wr_data_i[CTL_FCK];
      end
      if (wr_en_i && (wr_addr_i == ADDR_MATCH))
        match_q <= wr_data_i[CNT_W-1:0];
    end
  end

  // force bit is a strobe: never stored in the readable word
  always_comb begin
    ctrl_word = '0;
    ctrl_word[1:0]              = ctrl_q.mode;
    ctrl_word[CTL_ESEL]         = ctrl_q.edge_sel;
    ctrl_word[CTL_EPOL]         = ctrl_q.edge_pol;
    ctrl_word[CTL_FEN]          = ctrl_q.flag_en;
    ctrl_word[CTL_DMA]          = ctrl_q.dma_sel;
    ctrl_word[CTL_BSEL +: SEL_W] = ctrl_q.bus_sel;
    ctrl_word[CTL_FCK]          = ctrl_q.filt_clk_sel;
  end

  always_comb begin
    unique case (rd_addr_i)
      ADDR_CTRL:  rd_data_o = ctrl_word;
      ADDR_MATCH: rd_data_o = DATA_W'(match_q);
      ADDR_STAT:  rd_data_o = DATA_W'(flag_i);
      default:    rd_data_o = '0;
    endcase
  end

  assign ctrl_o     = ctrl_q;
  assign match_o    = match_q;
  assign force_o    = force_q;
  assign flag_clr_o = wr_en_i && (wr_addr_i == ADDR_STAT) && wr_data_i[0];
endmodule

// File: rtl/tmr_oc_tbase.sv
module tmr_oc_tbase import tmr_oc_pkg::*; #(
  parameter int CNT_W = 16,
  parameter int N_BUS = 3
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [N_BUS-1:0][CNT_W-1:0] cnt_bus_i,
  input  logic [SEL_W-1:0]            bus_sel_i,
  output logic [CNT_W-1:0]            tbase_o
);
  logic [CNT_W-1:0] local_cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) local_cnt_q <= '0;
    else         local_cnt_q <= local_cnt_q + 1'b1;
  end

  // codes beyond the bus count fall through to the local counter
  always_comb begin
    tbase_o = local_cnt_q;
    for (int i = 0; i < N_BUS; i++)
      if (bus_sel_i == SEL_W'(i)) tbase_o = cnt_bus_i[i];
  end
endmodule

// File: rtl/tmr_oc_edge.sv
module tmr_oc_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic rise_o,
  output logic fall_o
);
  logic sync1_q, sync2_q, prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync1_q <= 1'b0;
      sync2_q <= 1'b0;
      prev_q  <= 1'b0;
    end else begin
      sync1_q <= pin_i;
      sync2_q <= sync1_q;
      prev_q  <= sync2_q;
    end
  end

  assign rise_o = sync2_q & ~prev_q;
  assign fall_o = ~sync2_q & prev_q;
endmodule

// File: rtl/tmr_oc_chan.sv
module tmr_oc_chan import tmr_oc_pkg::*; #(
  parameter int CNT_W  = 16,
  parameter int DATA_W = 16,
  parameter int N_BUS  = 3
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        wr_en_i,
  input  logic [1:0]                  wr_addr_i,
  input  logic [DATA_W-1:0]           wr_data_i,
  input  logic [1:0]                  rd_addr_i,
  output logic [DATA_W-1:0]           rd_data_o,
  input  logic [N_BUS-1:0][CNT_W-1:0] cnt_bus_i,
  input  logic                        presc_tick_i,
  output logic                        filt_clk_en_o,
  input  logic                        pin_i,
  output logic                        pin_o,
  output logic                        flag_o,
  output logic                        irq_o,
  output logic                        dma_o
);
  chan_ctrl_t       ctrl;
  logic [CNT_W-1:0] match_a, tbase;
  logic force_q, flag_clr, rise, fall;
  logic oc_mode, in_mode, cmp_eq, act, edge_hit, flag_set;
  logic edge_sel, edge_pol;
  logic out_q, flag_q;

  tmr_oc_regs #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
    .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o), .flag_i(flag_q),
    .ctrl_o(ctrl), .match_o(match_a), .force_o(force_q), .flag_clr_o(flag_clr)
  );

  tmr_oc_tbase #(.CNT_W(CNT_W), .N_BUS(N_BUS)) u_tbase (
    .clk_i(clk_i), .rst_ni(rst_ni), .cnt_bus_i(cnt_bus_i),
    .bus_sel_i(ctrl.bus_sel), .tbase_o(tbase)
  );

  tmr_oc_edge u_edge (
    .clk_i(clk_i), .rst_ni(rst_ni), .pin_i(pin_i), .rise_o(rise), .fall_o(fall)
  );

  assign edge_sel = ctrl.edge_sel;
  assign edge_pol = ctrl.edge_pol;
  assign oc_mode  = (ctrl.mode == MODE_OC);
  assign in_mode  = (ctrl.mode == MODE_PIN_IN);
  assign cmp_eq   = (tbase == match_a);
  // force merges with a real hit: one action per edge
  assign act      = oc_mode && (cmp_eq || force_q);
  assign edge_hit = in_mode && !edge_sel && (edge_pol ? rise : fall);
  assign flag_set = (oc_mode && cmp_eq) || edge_hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_q  <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      if (act) out_q <= edge_sel ? ~out_q : edge_pol;
      if (flag_set)      flag_q <= 1'b1;
      else if (flag_clr) flag_q <= 1'b0;
    end
  end

  assign pin_o         = out_q;
  assign flag_o        = flag_q;
  assign irq_o         = flag_q && ctrl.flag_en && !ctrl.dma_sel;
  assign dma_o         = flag_q && ctrl.flag_en && ctrl.dma_sel;
  assign filt_clk_en_o = ctrl.filt_clk_sel ? 1'b1 : presc_tick_i;
endmodule

// File: rtl/tmr_oc_chk.sv
module tmr_oc_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic pin_o,
  input logic flag_o,
  input logic irq_o,
  input logic dma_o,
  input logic oc_mode,
  input logic act,
  input logic edge_sel,
  input logic edge_pol,
  input logic flag_set,
  input logic flag_clr
);
  a_r2_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act && !edge_sel) |=> (pin_o == $past(edge_pol)));

  a_r3_toggle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act && edge_sel) |=> (pin_o != $past(pin_o)));

  a_r7_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oc_mode |=> $stable(pin_o));

  a_r8_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_set |=> flag_o);

  a_r8_clr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_clr && !flag_set) |=> !flag_o);

  a_r9_one_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(irq_o && dma_o));

  a_r9_req_needs_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o || dma_o) |-> flag_o);
endmodule

bind tmr_oc_chan tmr_oc_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .pin_o(pin_o), .flag_o(flag_o),
  .irq_o(irq_o), .dma_o(dma_o), .oc_mode(oc_mode), .act(act),
  .edge_sel(edge_sel), .edge_pol(edge_pol), .flag_set(flag_set),
  .flag_clr(flag_clr)
);

// File: tb/tmr_oc_chan_bench.sv
`timescale 1ns/1ps
module tmr_oc_chan_bench;
  localparam int CNT_W = 8;
  localparam int DATA_W = 16;
  localparam int N_BUS = 3;
  localparam logic [CNT_W-1:0] MVAL = 8'h55;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [DATA_W-1:0] wr_data = '0;
  logic [1:0] rd_addr = '0;
  logic [DATA_W-1:0] rd_data;
  logic [N_BUS-1:0][CNT_W-1:0] bus = '0;
  logic presc_tick = 1'b0;
  logic filt_en, pin_in, pin_out, flag, irq, dma;
  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  initial pin_in = 1'b0;
  always #2.5 clk = ~clk;

  tmr_oc_chan #(.CNT_W(CNT_W), .DATA_W(DATA_W), .N_BUS(N_BUS)) u_tmr_oc_chan (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .cnt_bus_i(bus), .presc_tick_i(presc_tick), .filt_clk_en_o(filt_en),
    .pin_i(pin_in), .pin_o(pin_out), .flag_o(flag), .irq_o(irq), .dma_o(dma)
  );

  // vector: {bus_sel[1:0], edge_sel, edge_pol, expected pin}
  localparam logic [4:0] VEC [8] = '{
    5'b00_0_1_1, 5'b01_0_0_0, 5'b10_1_0_1, 5'b00_1_0_0,
    5'b01_1_0_1, 5'b10_0_1_1, 5'b10_0_0_0, 5'b00_1_0_1
  };

  task automatic chk(input string req, input logic [15:0] act_v, input logic [15:0] exp_v);
    n_run++;
    if (act_v !== exp_v) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act_v, exp_v);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [DATA_W-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  function automatic logic [DATA_W-1:0] ctl(input logic [1:0] mode, input logic esel,
      input logic epol, input logic frc, input logic fen, input logic dsel,
      input logic [1:0] bsel, input logic fck);
    logic [DATA_W-1:0] w;
    w = '0;
    w[1:0] = mode; w[2] = esel; w[3] = epol; w[4] = frc;
    w[5] = fen; w[6] = dsel; w[8:7] = bsel; w[9] = fck;
    return w;
  endfunction

  // drive MVAL on masked buses for exactly one capturing edge
  task automatic pulse(input logic [N_BUS-1:0] mask);
    for (int b = 0; b < N_BUS; b++) bus[b] = mask[b] ? MVAL : '0;
    @(negedge clk);
    bus = '0;
  endtask

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    logic exp_pin;
    logic [1:0] sel;
    bit seen;
    #12 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd_addr = 2'd0;
    #0.1;
    chk("R1 ctrl", rd_data, 16'h0);
    chk("R1 pin", {15'b0, pin_out}, 16'h0);
    chk("R1 flag", {15'b0, flag}, 16'h0);
    chk("R1 req", {14'b0, irq, dma}, 16'h0);

    wr(2'd1, DATA_W'(MVAL));

    // R2 R3 R4 R8 table walk
    for (int v = 0; v < 8; v++) begin
      sel = VEC[v][4:3];
      exp_pin = VEC[v][0];
      wr(2'd0, ctl(2'b10, VEC[v][2], VEC[v][1], 1'b0, 1'b1, 1'b0, sel, 1'b0));
      wr(2'd2, 16'h1);
      begin
        logic prev;
        prev = pin_out;
        pulse(~(N_BUS'(1) << sel));
        chk("R4 unselected bus pin", {15'b0, pin_out}, {15'b0, prev});
        chk("R4 unselected bus flag", {15'b0, flag}, 16'h0);
      end
      pulse(N_BUS'(1) << sel);
      chk(VEC[v][2] ? "R3 toggle" : "R2 load", {15'b0, pin_out}, {15'b0, exp_pin});
      chk("R8 flag with match", {15'b0, flag}, 16'h1);
      chk("R9 irq", {15'b0, irq}, 16'h1);
    end

    // R5 force strobe: pin 1 -> 0, no flag
    wr(2'd2, 16'h1);
    wr(2'd0, ctl(2'b10, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 2'd0, 1'b0));
    @(negedge clk);
    chk("R5 force pin", {15'b0, pin_out}, 16'h0);
    chk("R5 force no flag", {15'b0, flag}, 16'h0);
    rd_addr = 2'd0;
    #0.1;
    chk("R5 force reads 0", {15'b0, rd_data[4]}, 16'h0);
    chk("R5 ctrl stored", {15'b0, rd_data[2]}, 16'h1);

    // R6 force + match same edge: single toggle 0 -> 1
    wr(2'd0, ctl(2'b10, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 2'd0, 1'b0));
    pulse(3'b001);
    chk("R6 single action", {15'b0, pin_out}, 16'h1);
    chk("R6 flag from match", {15'b0, flag}, 16'h1);

    // R9 routing
    wr(2'd2, 16'h1);
    wr(2'd0, ctl(2'b10, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 2'd0, 1'b0));
    pulse(3'b001);
    chk("R9 dma route", {14'b0, irq, dma}, 16'h1);
    wr(2'd0, ctl(2'b10, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 2'd0, 1'b0));
    chk("R9 disabled req", {14'b0, irq, dma}, 16'h0);
    chk("R9 flag kept", {15'b0, flag}, 16'h1);
    wr(2'd0, ctl(2'b10, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 2'd0, 1'b0));
    chk("R9 irq route", {14'b0, irq, dma}, 16'h2);
    wr(2'd2, 16'h1);
    chk("R8 clear flag", {15'b0, flag}, 16'h0);
    chk("R8 clear req", {14'b0, irq, dma}, 16'h0);

    // R7 force and match in input mode (pin is 1)
    wr(2'd0, ctl(2'b01, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 2'd0, 1'b0));
    wait_cyc(2);
    chk("R7 force ignored", {15'b0, pin_out}, 16'h1);
    pulse(3'b001);
    chk("R7 match ignored pin", {15'b0, pin_out}, 16'h1);
    chk("R7 match ignored flag", {15'b0, flag}, 16'h0);

    // R10 input edges, polarity 1 rising
    pin_in = 1'b1;
    wait_cyc(2);
    chk("R10 latency", {15'b0, flag}, 16'h0);
    @(negedge clk);
    chk("R10 rising flag", {15'b0, flag}, 16'h1);
    wr(2'd2, 16'h1);
    pin_in = 1'b0;
    wait_cyc(4);
    chk("R10 falling ignored pol1", {15'b0, flag}, 16'h0);
    wr(2'd0, ctl(2'b01, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 2'd0, 1'b0));
    pin_in = 1'b1; wait_cyc(4);
    pin_in = 1'b0; wait_cyc(4);
    chk("R10 edge sel suppresses", {15'b0, flag}, 16'h0);
    wr(2'd0, ctl(2'b01, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 2'd0, 1'b0));
    pin_in = 1'b1; wait_cyc(4);
    chk("R10 rising ignored pol0", {15'b0, flag}, 16'h0);
    pin_in = 1'b0; wait_cyc(3);
    chk("R10 falling flag pol0", {15'b0, flag}, 16'h1);
    wr(2'd2, 16'h1);

    // R11 filter clock mux
    presc_tick = 1'b0;
    #0.1;
    chk("R11 prescaled low", {15'b0, filt_en}, 16'h0);
    presc_tick = 1'b1;
    #0.1;
    chk("R11 prescaled high", {15'b0, filt_en}, 16'h1);
    presc_tick = 1'b0;
    wr(2'd0, ctl(2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 1'b1));
    chk("R11 main clock", {15'b0, filt_en}, 16'h1);

    // R4 local counter as time base (code 3)
    wr(2'd2, 16'h1);
    wr(2'd0, ctl(2'b10, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 2'd3, 1'b0));
    seen = 1'b0;
    for (int i = 0; i < 600 && !seen; i++) begin
      @(negedge clk);
      if (flag) seen = 1'b1;
    end
    chk("R4 local counter match", {15'b0, seen}, 16'h1);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #50000;
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule